// File: doc/BRIEF.md
# Start-Up Voltage Estimator and Restart Sequencer

This block produces the first open-circuit voltage estimate a fuel gauge needs when it starts up. The estimate is taken once after reset, and again whenever a restart is requested. Once a start event has occurred, the block watches a millisecond tick. It samples the 12-bit cell voltage on each of the next sixteen ticks and keeps the largest reading. On the seventeenth tick it publishes that value and raises a ready flag. A second flag rises a fixed number of ticks later to tell the downstream model that its first state-of-charge result may be used.

Restarts come from three sources. The first is a rising edge on an asynchronous hardware pin, which is synchronized on chip. The second is a one-cycle command pulse from the register file. The third is the battery-swap detector, which watches for the cell dropping below a programmable reset threshold and then recovering. Recovery is confirmed in one of two ways:
- by a fast analog comparator after a single tick;
- by the digitized sample staying at or above the threshold for 250 consecutive ticks, when the comparator is switched off during hibernate.

Top module: `ocv_start_seq`

## Requirements
- R1: While `rst` is high, `ocv_ready` and `soc_ready` are 0 and `ocv_est` reads 0. Releasing reset starts a sequence with no other stimulus.
- R2: After a start event, `cell_smp` is sampled on each of the first 16 ticks. The estimate is the largest of these 16 values, compared as unsigned numbers. A sample presented on any later tick never enters the estimate.
- R3: `ocv_ready` rises on the 17th tick after a start event, and `ocv_est` then holds the estimate until the next start event. While `ocv_ready` is 0, `ocv_est` reads 0.
- R4: `soc_ready` rises on the 175th tick after `ocv_ready` rose. `soc_ready` is never 1 while `ocv_ready` is 0.
- R5: A rising edge on `qs_pin` starts a sequence once it has passed a two-flop synchronizer. Holding the pin high, or lowering it, causes no further start.
- R6: A one-cycle pulse on `qs_cmd` starts a sequence.
- R7: A start event in any phase clears both ready flags and resets the tick count and the running maximum to zero.
- R8: The reset threshold in sample units (1.25 mV per LSB) is the code clamped to the range 57..87, multiplied by 32. This gives 40 mV steps from 2.28 V to 3.48 V. Codes outside that range use the nearest end.
- R9: The comparator path is used unless both `comp_dis` and `hib_active` are 1. On that path, any cycle with `cmp_above` at 0 arms the detector. The first tick with `cmp_above` at 1 after arming starts a sequence.
- R10: When `comp_dis` and `hib_active` are both 1, `cmp_above` is ignored. A tick with `cell_smp` below the threshold arms the detector and zeroes its count. A sequence starts on the 250th consecutive tick with `cell_smp` at or above the threshold. A sample equal to the threshold counts as above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a sequence on release |
| tick_ms | input | 1 | One-cycle pulse every millisecond; `cell_smp` is valid with it |
| cell_smp | input | 12 | Cell voltage sample, 1.25 mV per LSB |
| cmp_above | input | 1 | Fast comparator: cell above reset threshold |
| comp_dis | input | 1 | Turns the comparator path off while in hibernate |
| hib_active | input | 1 | Gauge is in hibernate |
| vrst_code | input | 7 | Reset threshold code, 40 mV per step |
| qs_pin | input | 1 | Asynchronous quick-start pin, rising edge active |
| qs_cmd | input | 1 | Quick-start command pulse from the register file |
| ocv_est | output | 12 | Open-circuit voltage estimate |
| ocv_ready | output | 1 | Estimate valid |
| soc_ready | output | 1 | First state-of-charge result may be used |

## Verification
The bench targets the edges of the sampling window.
- The maximum is placed on the first sample and on the sixteenth. A larger value is presented on the seventeenth tick. An off-by-one window would either miss a real peak or publish the intruder.
- A restart is issued midway through a burst of full-scale samples. A design that kept its running maximum or tick count would report the old peak or raise ready too early.

The swap detector is checked on several points.
- The slow path fires on exactly the 250th recovered tick, and a fresh dip resets its count.
- The comparator is ignored while it is disabled.
- Threshold codes at 0 and 127 must be clamped. An unclamped threshold would never arm, or never recover when the sample sits exactly on the clamped limit.

// File: rtl/qsseq_pkg.sv
package qsseq_pkg;

    localparam int SMP_W  = 12;
    localparam int CODE_W = 7;

    typedef enum logic [1:0] {
        PH_DEBOUNCE,
        PH_SETTLE,
        PH_DONE
    } phase_e;

    // Recovery-detection mode chosen from comparator enable and threshold
    typedef struct packed {
        logic             fast;
        logic [SMP_W-1:0] thr;
    } swap_mode_t;

    // Threshold code to sample units, clamped to the legal code range
    function automatic logic [SMP_W-1:0] code_to_thr(
        input logic [CODE_W-1:0] code,
        input int                cmin,
        input int                cmax,
        input int                step
    );
        int c;
        c = int'(code);
        if (c < cmin) c = cmin;
        if (c > cmax) c = cmax;
        return SMP_W'(c * step);
    endfunction

endpackage

// File: rtl/ocv_qs_sync.sv
module ocv_qs_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;

    // R5
    pin_single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ocv_swap_detect.sv
module ocv_swap_detect
    import qsseq_pkg::*;
#(
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SMP_W-1:0] sample,
    input  logic             cmp_above,
    input  swap_mode_t       mode,
    output logic             fire
);
    localparam int LIM_MAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic          armed;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;
    logic          below;
    logic          above_tick;

    always_comb begin
        limit      = mode.fast ? CW'(FAST_TICKS) : CW'(SLOW_TICKS);
        below      = mode.fast ? ~cmp_above : (tick && (sample < mode.thr));
        above_tick = tick && (mode.fast ? cmp_above : (sample >= mode.thr));
        cnt_inc    = cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (below) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && above_tick) begin
                if (cnt_inc >= limit) begin
                    fire  <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

    // R10
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !fire);

    // R9
    fire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/ocv_peak_seq.sv
module ocv_peak_seq
    import qsseq_pkg::*;
#(
    parameter int N_SAMPLES = 16,
    parameter int OCV_TICKS = 17,
    parameter int SOC_TICKS = 175
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SMP_W-1:0] sample,
    input  logic             start,
    output logic [SMP_W-1:0] ocv_est,
    output logic             ocv_ready,
    output logic             soc_ready
);
    localparam int CNT_MAX = (OCV_TICKS > SOC_TICKS) ? OCV_TICKS : SOC_TICKS;
    localparam int CW      = $clog2(CNT_MAX + 1);

    phase_e           phase;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    cnt_inc;
    logic [SMP_W-1:0] peak;
    logic [SMP_W-1:0] peak_nx;

    always_comb begin
        cnt_inc = cnt + CW'(1);
        peak_nx = peak;
        if ((cnt < CW'(N_SAMPLES)) && (sample > peak)) peak_nx = sample;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            phase     <= PH_DEBOUNCE;
            cnt       <= '0;
            peak      <= '0;
            ocv_est   <= '0;
            ocv_ready <= 1'b0;
            soc_ready <= 1'b0;
        end else if (tick) begin
            case (phase)
                PH_DEBOUNCE: begin
                    peak <= peak_nx;
                    if (cnt_inc == CW'(OCV_TICKS)) begin
                        ocv_est   <= peak_nx;
                        ocv_ready <= 1'b1;
                        phase     <= PH_SETTLE;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_SETTLE: begin
                    if (cnt_inc == CW'(SOC_TICKS)) begin
                        soc_ready <= 1'b1;
                        phase     <= PH_DONE;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4
    soc_after_ocv_chk: assert property (@(posedge clk) disable iff (rst)
        soc_ready |-> ocv_ready);

    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ocv_ready && !soc_ready && ocv_est == '0));

    // R3
    est_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ocv_ready && !start) |=> $stable(ocv_est));

    // R3
    est_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ocv_ready |-> (ocv_est == '0));

    // R2
    peak_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEBOUNCE && !start) |=> (peak >= $past(peak)));

endmodule

// File: rtl/ocv_start_seq.sv
module ocv_start_seq
    import qsseq_pkg::*;
#(
    parameter int N_SAMPLES  = 16,
    parameter int OCV_TICKS  = 17,
    parameter int SOC_TICKS  = 175,
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 250,
    parameter int CODE_MIN   = 57,
    parameter int CODE_MAX   = 87,
    parameter int STEP_LSB   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ms,
    input  logic [SMP_W-1:0]  cell_smp,
    input  logic              cmp_above,
    input  logic              comp_dis,
    input  logic              hib_active,
    input  logic [CODE_W-1:0] vrst_code,
    input  logic              qs_pin,
    input  logic              qs_cmd,
    output logic [SMP_W-1:0]  ocv_est,
    output logic              ocv_ready,
    output logic              soc_ready
);
    logic       pin_rise;
    logic       swap_fire;
    logic       start;
    swap_mode_t mode;

    always_comb begin
        mode.fast = ~(comp_dis & hib_active);
        mode.thr  = code_to_thr(vrst_code, CODE_MIN, CODE_MAX, STEP_LSB);
        start     = pin_rise | qs_cmd | swap_fire;
    end

    ocv_qs_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (qs_pin),
        .rise      (pin_rise)
    );

    ocv_swap_detect #(
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_swap (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_ms),
        .sample    (cell_smp),
        .cmp_above (cmp_above),
        .mode      (mode),
        .fire      (swap_fire)
    );

    ocv_peak_seq #(
        .N_SAMPLES (N_SAMPLES),
        .OCV_TICKS (OCV_TICKS),
        .SOC_TICKS (SOC_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_ms),
        .sample    (cell_smp),
        .start     (start),
        .ocv_est   (ocv_est),
        .ocv_ready (ocv_ready),
        .soc_ready (soc_ready)
    );

    // R6
    cmd_restart_chk: assert property (@(posedge clk) disable iff (rst)
        qs_cmd |=> !ocv_ready);

endmodule

// File: tb/ocv_start_seq_tb.sv
module ocv_start_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic [11:0] cell_smp = '0;
    logic        cmp_above = 1'b1;
    logic        comp_dis = 1'b0;
    logic        hib_active = 1'b0;
    logic [6:0]  vrst_code = 7'd75;
    logic        qs_pin = 1'b0;
    logic        qs_cmd = 1'b0;
    logic [11:0] ocv_est;
    logic        ocv_ready;
    logic        soc_ready;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    ocv_start_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_ms    (tick_ms),
        .cell_smp   (cell_smp),
        .cmp_above  (cmp_above),
        .comp_dis   (comp_dis),
        .hib_active (hib_active),
        .vrst_code  (vrst_code),
        .qs_pin     (qs_pin),
        .qs_cmd     (qs_cmd),
        .ocv_est    (ocv_est),
        .ocv_ready  (ocv_ready),
        .soc_ready  (soc_ready)
    );

    // Sample vectors: 16 samples per start event, and the expected peak
    localparam logic [11:0] VS [4][16] = '{
        '{12'hABC, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800,
          12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800, 12'h800},
        '{12'h010, 12'h020, 12'h030, 12'h040, 12'h050, 12'h060, 12'h070, 12'h080,
          12'h090, 12'h0A0, 12'h0B0, 12'h0C0, 12'h0D0, 12'h0E0, 12'h0F0, 12'hFFD},
        '{12'hF00, 12'hE00, 12'hD00, 12'hC00, 12'hB00, 12'hA00, 12'h900, 12'h800,
          12'h700, 12'h600, 12'h500, 12'h400, 12'h300, 12'h200, 12'h100, 12'h000},
        '{12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123,
          12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123, 12'h123}
    };
    localparam logic [11:0] VE [4] = '{12'hABC, 12'hFFD, 12'hF00, 12'h123};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [11:0] s);
        @(negedge clk);
        tick_ms  = 1'b1;
        cell_smp = s;
        @(negedge clk);
        tick_ms = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n, input logic [11:0] s);
        for (int i = 0; i < n; i++) tick(s);
    endtask

    task automatic cmd_pulse();
        @(negedge clk);
        qs_cmd = 1'b1;
        @(negedge clk);
        qs_cmd = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ocv_ready in reset", 32'(ocv_ready), 0);
        chk("R1 soc_ready in reset", 32'(soc_ready), 0);
        chk("R1 ocv_est in reset", 32'(ocv_est), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: start source per vector is reset, cmd, pin, cmd
        for (int v = 0; v < 4; v++) begin
            if (v == 1 || v == 3) begin
                cmd_pulse();
                repeat (2) @(negedge clk);
                chk("R6 cmd clears ready", 32'(ocv_ready), 0);
            end else if (v == 2) begin
                @(negedge clk);
                qs_pin = 1'b1;
                repeat (4) @(negedge clk);
                chk("R5 pin edge clears ready", 32'(ocv_ready), 0);
                chk("R5 pin edge clears soc", 32'(soc_ready), 0);
            end
            for (int k = 0; k < 16; k++) tick(VS[v][k]);
            chk("R3 not ready after 16 ticks", 32'(ocv_ready), 0);
            chk("R3 est zero before ready", 32'(ocv_est), 0);
            tick(12'hFFE);
            chk("R3 ready on tick 17", 32'(ocv_ready), 1);
            chk("R2 peak of 16 samples", 32'(ocv_est), 32'(VE[v]));
            ticks(174, 12'h555);
            chk("R4 soc not ready at 174", 32'(soc_ready), 0);
            tick(12'h555);
            chk("R4 soc ready at 175", 32'(soc_ready), 1);
            chk("R3 est held", 32'(ocv_est), 32'(VE[v]));
        end

        // R5: holding and lowering the pin must not restart
        repeat (10) @(negedge clk);
        chk("R5 held pin no restart", 32'(soc_ready), 1);
        qs_pin = 1'b0;
        repeat (10) @(negedge clk);
        chk("R5 falling pin no restart", 32'(soc_ready), 1);

        // R7: restart in the middle of debounce
        cmd_pulse();
        ticks(8, 12'hFFF);
        cmd_pulse();
        repeat (2) @(negedge clk);
        chk("R7 restart clears ready", 32'(ocv_ready), 0);
        ticks(16, 12'h200);
        chk("R7 count restarted", 32'(ocv_ready), 0);
        tick(12'hFFE);
        chk("R7 ready after fresh window", 32'(ocv_ready), 1);
        chk("R7 max cleared on restart", 32'(ocv_est), 32'h200);
        ticks(3, 12'h555);
        cmd_pulse();
        repeat (2) @(negedge clk);
        chk("R7 restart during settle", 32'(ocv_ready), 0);
        ticks(192, 12'hBB8);
        chk("R4 back to soc ready", 32'(soc_ready), 1);

        // R9: comparator path, recovery on the first tick
        @(negedge clk);
        cmp_above = 1'b0;
        repeat (3) @(negedge clk);
        cmp_above = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no restart before tick", 32'(soc_ready), 1);
        tick(12'hBB8);
        chk("R9 fast recovery restarts", 32'(ocv_ready), 0);
        ticks(192, 12'hBB8);
        chk("R9 sequence completes", 32'(ocv_est), 32'hBB8);

        // R9: comparator still used when disabled bit set outside hibernate
        comp_dis = 1'b1;
        @(negedge clk);
        cmp_above = 1'b0;
        repeat (2) @(negedge clk);
        cmp_above = 1'b1;
        tick(12'hBB8);
        chk("R9 comparator active when awake", 32'(ocv_ready), 0);
        ticks(192, 12'hBB8);

        // R10: slow path, threshold code 75 -> 2400
        hib_active = 1'b1;
        @(negedge clk);
        cmp_above = 1'b0;
        repeat (3) @(negedge clk);
        cmp_above = 1'b1;
        ticks(5, 12'hBB8);
        chk("R10 comparator ignored", 32'(soc_ready), 1);
        tick(12'd100);
        ticks(100, 12'hBB8);
        tick(12'd100);
        ticks(249, 12'hBB8);
        chk("R10 no restart at 249", 32'(soc_ready), 1);
        tick(12'hBB8);
        chk("R10 restart at 250", 32'(ocv_ready), 0);
        ticks(192, 12'hBB8);

        // R8: code 0 clamps to 1824
        vrst_code = 7'd0;
        tick(12'd1800);
        ticks(249, 12'd1900);
        chk("R8 low clamp no restart at 249", 32'(soc_ready), 1);
        tick(12'd1900);
        chk("R8 low clamp arms and recovers", 32'(ocv_ready), 0);
        ticks(192, 12'd1900);

        // R8: code 127 clamps to 2784; equal sample counts as above
        vrst_code = 7'd127;
        tick(12'd100);
        ticks(249, 12'd2784);
        chk("R8 high clamp no restart at 249", 32'(soc_ready), 1);
        tick(12'd2784);
        chk("R8 high clamp recovers at threshold", 32'(ocv_ready), 0);

        summary();
        $finish;
    end

endmodule